// File: doc/BRIEF.md
# Load Ordering Queue with Store Conflict Search

This block tracks loads that are in flight, in program order. Each entry holds a sequence number and, once the load has executed, its effective address. Dispatch allocates an entry at the young end and is told the slot index it received. Execution later writes the load's address into that slot. Commit retires loads from the old end. A squash drops loads from the young end.

When a store executes, the queue checks whether any younger load that already has an address falls in the same 256-byte region as the store. If one does, that load has run ahead of a store it depended on. The block flags a fault for the store and records the oldest such load as the violator. The record stays until the consumer reads it. While a violator is recorded, later stores are not searched.

The queue also holds a single pending blocked-load mark. A squash that is older than the marked load clears it.

Top module: `load_order_queue`

## Requirements
- R1: After reset the queue is empty: `lq_count`=0, `alloc_full`=0, `alloc_idx`=0, `viol_valid`=0, `st_fault`=0 and `blk_pending`=0.
- R2: An accepted allocation takes the slot shown on `alloc_idx`. Slots are handed out in increasing order modulo DEPTH, and `lq_count` rises by one on the next cycle.
- R3: When `lq_count` equals DEPTH, `alloc_full` is 1. An allocation request in that state is dropped and `lq_count` does not change.
- R4: A commit retires every head load whose sequence number is less than or equal to `commit_seq`. Their slots return to the pool, and later allocations reuse them after the tail wraps.
- R5: A squash removes every load whose sequence number is greater than `squash_seq`, and `alloc_idx` moves back to the oldest removed slot. In the same cycle, a squash takes priority and any commit or allocation request is dropped.
- R6: A store check (`st_valid`) flags a conflict when an eligible load matches the store on address bits 8 and up. One cycle later `st_fault` pulses high, `viol_valid`=1, and `viol_seq` and `viol_idx` name the load.
- R7: Address bits 7..0 take no part in the comparison. A load in a different 256-byte region never conflicts.
- R8: Loads whose sequence number is less than or equal to the store's are never flagged. A load whose address has not yet been written is never flagged.
- R9: When several loads conflict, the oldest one in program order is reported.
- R10: While `viol_valid` is 1, a store check does no search and gives no fault, and the record stays unchanged. `viol_read` clears `viol_valid` on the next cycle.
- R11: `blk_set` sets `blk_pending` and stores `blk_seq`. A squash clears `blk_pending` only if `squash_seq` is less than the stored sequence number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| alloc_valid | input | 1 | Allocate a load at the young end |
| alloc_seq | input | SEQ_W | Sequence number of the new load |
| alloc_idx | output | $clog2(DEPTH) | Slot the next allocation takes |
| alloc_full | output | 1 | Queue holds DEPTH loads |
| lq_count | output | $clog2(DEPTH)+1 | Number of loads held |
| upd_valid | input | 1 | Write the executed address of a load |
| upd_idx | input | $clog2(DEPTH) | Slot to update |
| upd_addr | input | ADDR_W | Effective address of the load |
| st_valid | input | 1 | A store executes; search for conflicts |
| st_seq | input | SEQ_W | Sequence number of the store |
| st_addr | input | ADDR_W | Effective address of the store |
| st_fault | output | 1 | One-cycle pulse: the store found a conflict |
| viol_valid | output | 1 | A violator is recorded |
| viol_seq | output | SEQ_W | Sequence number of the violating load |
| viol_idx | output | $clog2(DEPTH) | Slot of the violating load |
| viol_read | input | 1 | Consume and clear the violator record |
| commit_valid | input | 1 | Commit up to commit_seq |
| commit_seq | input | SEQ_W | Youngest committed sequence number |
| squash_valid | input | 1 | Squash loads younger than squash_seq |
| squash_seq | input | SEQ_W | Sequence number of the squash point |
| blk_set | input | 1 | Mark a load as blocked |
| blk_seq | input | SEQ_W | Sequence number of the blocked load |
| blk_pending | output | 1 | A blocked-load mark is active |

## Verification
The assertions rely on the following input rules:
- Sequence numbers rise with program order and do not wrap while loads are held.
- `upd_idx` only names slots that hold a live load.
- A commit never reaches past a squash point given in the same cycle.

The stimulus keeps to these rules. It allocates sequence numbers 10 and up in increasing order, updates only slot indices that it read back from `alloc_idx`, and issues commits and squashes one at a time, except for the single case that checks squash priority over allocation.

// File: rtl/load_order_queue.sv
module load_order_queue #(
  parameter int DEPTH      = 8,
  parameter int SEQ_W      = 16,
  parameter int ADDR_W     = 32,
  parameter int REGION_LSB = 8,
  localparam int IW        = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic [SEQ_W-1:0]  alloc_seq,
  output logic [IW-1:0]     alloc_idx,
  output logic              alloc_full,
  output logic [IW:0]       lq_count,
  input  logic              upd_valid,
  input  logic [IW-1:0]     upd_idx,
  input  logic [ADDR_W-1:0] upd_addr,
  input  logic              st_valid,
  input  logic [SEQ_W-1:0]  st_seq,
  input  logic [ADDR_W-1:0] st_addr,
  output logic              st_fault,
  output logic              viol_valid,
  output logic [SEQ_W-1:0]  viol_seq,
  output logic [IW-1:0]     viol_idx,
  input  logic              viol_read,
  input  logic              commit_valid,
  input  logic [SEQ_W-1:0]  commit_seq,
  input  logic              squash_valid,
  input  logic [SEQ_W-1:0]  squash_seq,
  input  logic              blk_set,
  input  logic [SEQ_W-1:0]  blk_seq,
  output logic              blk_pending
);

  logic [DEPTH-1:0]  live, has_addr;
  logic [SEQ_W-1:0]  seq_q  [DEPTH];
  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [IW-1:0]     head, tail;
  logic [IW:0]       cnt;
  logic [SEQ_W-1:0]  blk_seq_q;

  logic [IW:0]   retire_n, kill_n;
  logic          hit;
  logic [IW-1:0] hit_slot, slot;
  logic          take;

  assign alloc_idx  = tail;
  assign lq_count   = cnt;
  assign alloc_full = (cnt == (IW+1)'(DEPTH));
  assign take       = alloc_valid && !alloc_full;

  always_comb begin
    retire_n = '0;
    kill_n   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (live[i] && seq_q[i] <= commit_seq) retire_n = retire_n + 1'b1;
      if (live[i] && seq_q[i] >  squash_seq) kill_n   = kill_n + 1'b1;
    end
  end

  always_comb begin
    hit      = 1'b0;
    hit_slot = '0;
    slot     = '0;
    for (int k = 0; k < DEPTH; k++) begin
      slot = head + IW'(k);
      if (!hit && live[slot] && has_addr[slot] && seq_q[slot] > st_seq &&
          addr_q[slot][ADDR_W-1:REGION_LSB] == st_addr[ADDR_W-1:REGION_LSB]) begin
        hit      = 1'b1;
        hit_slot = slot;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live        <= '0;
      has_addr    <= '0;
      head        <= '0;
      tail        <= '0;
      cnt         <= '0;
      st_fault    <= 1'b0;
      viol_valid  <= 1'b0;
      viol_seq    <= '0;
      viol_idx    <= '0;
      blk_pending <= 1'b0;
      blk_seq_q   <= '0;
    end else begin
      st_fault <= 1'b0;
      if (viol_valid) begin
        if (viol_read) viol_valid <= 1'b0;
      end else if (st_valid && hit) begin
        viol_valid <= 1'b1;
        viol_seq   <= seq_q[hit_slot];
        viol_idx   <= hit_slot;
        st_fault   <= 1'b1;
      end

      if (upd_valid && live[upd_idx]) begin
        addr_q[upd_idx]   <= upd_addr;
        has_addr[upd_idx] <= 1'b1;
      end

      if (squash_valid) begin
        for (int i = 0; i < DEPTH; i++)
          if (live[i] && seq_q[i] > squash_seq) live[i] <= 1'b0;
        tail <= tail - kill_n[IW-1:0];
        cnt  <= cnt - kill_n;
      end else begin
        if (commit_valid) begin
          for (int i = 0; i < DEPTH; i++)
            if (live[i] && seq_q[i] <= commit_seq) live[i] <= 1'b0;
          head <= head + retire_n[IW-1:0];
        end
        if (take) begin
          live[tail]     <= 1'b1;
          has_addr[tail] <= 1'b0;
          seq_q[tail]    <= alloc_seq;
          tail           <= tail + 1'b1;
        end
        cnt <= cnt - (commit_valid ? retire_n : '0) + (IW+1)'(take);
      end

      if (squash_valid && blk_pending && squash_seq < blk_seq_q) blk_pending <= 1'b0;
      if (blk_set) begin
        blk_pending <= 1'b1;
        blk_seq_q   <= blk_seq;
      end
    end
  end

endmodule

// File: rtl/load_order_queue_chk.sv
module load_order_queue_chk #(
  parameter int DEPTH = 8,
  parameter int SEQ_W = 16,
  localparam int IW   = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             alloc_valid,
  input logic             alloc_full,
  input logic [IW:0]      lq_count,
  input logic             st_valid,
  input logic             st_fault,
  input logic             viol_valid,
  input logic [SEQ_W-1:0] viol_seq,
  input logic             viol_read,
  input logic             commit_valid,
  input logic             squash_valid,
  input logic             blk_set,
  input logic             blk_pending
);

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lq_count <= (IW+1)'(DEPTH));

  assert_alloc_grows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && !alloc_full && !commit_valid && !squash_valid)
    |=> lq_count == $past(lq_count) + 1'b1);

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && alloc_full && !commit_valid && !squash_valid) |=> $stable(lq_count));

  assert_fault_recorded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    st_fault |-> viol_valid);

  assert_fault_needs_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !st_valid |=> !st_fault);

  assert_no_research_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_valid && st_valid) |=> !st_fault);

  assert_record_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_valid && !viol_read) |=> (viol_valid && $stable(viol_seq)));

  assert_read_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_valid && viol_read) |=> !viol_valid);

  assert_blk_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
    blk_set |=> blk_pending);

endmodule

bind load_order_queue load_order_queue_chk #(.DEPTH(DEPTH), .SEQ_W(SEQ_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_full(alloc_full),
  .lq_count(lq_count), .st_valid(st_valid), .st_fault(st_fault),
  .viol_valid(viol_valid), .viol_seq(viol_seq), .viol_read(viol_read),
  .commit_valid(commit_valid), .squash_valid(squash_valid),
  .blk_set(blk_set), .blk_pending(blk_pending)
);

// File: tb/load_order_queue_tb.sv
module load_order_queue_tb_top;
  localparam int DEPTH = 8, SEQ_W = 16, ADDR_W = 32, IW = 3;

  logic clk = 0, rst_n = 0;
  logic alloc_valid = 0; logic [SEQ_W-1:0] alloc_seq = '0;
  logic [IW-1:0] alloc_idx; logic alloc_full; logic [IW:0] lq_count;
  logic upd_valid = 0; logic [IW-1:0] upd_idx = '0; logic [ADDR_W-1:0] upd_addr = '0;
  logic st_valid = 0; logic [SEQ_W-1:0] st_seq = '0; logic [ADDR_W-1:0] st_addr = '0;
  logic st_fault, viol_valid; logic [SEQ_W-1:0] viol_seq; logic [IW-1:0] viol_idx;
  logic viol_read = 0;
  logic commit_valid = 0; logic [SEQ_W-1:0] commit_seq = '0;
  logic squash_valid = 0; logic [SEQ_W-1:0] squash_seq = '0;
  logic blk_set = 0; logic [SEQ_W-1:0] blk_seq = '0; logic blk_pending;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [IW-1:0] slot_of [64];

  always #5 clk = ~clk;

  load_order_queue #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .ADDR_W(ADDR_W)) dut_i (.*);

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_alloc(int s);
    slot_of[s] = alloc_idx;
    alloc_valid = 1; alloc_seq = SEQ_W'(s);
    @(negedge clk); alloc_valid = 0;
  endtask
  task automatic do_upd(int s, int a);
    upd_valid = 1; upd_idx = slot_of[s]; upd_addr = ADDR_W'(a);
    @(negedge clk); upd_valid = 0;
  endtask
  task automatic do_store(int s, int a);
    st_valid = 1; st_seq = SEQ_W'(s); st_addr = ADDR_W'(a);
    @(negedge clk); st_valid = 0;
  endtask
  task automatic do_commit(int s);
    commit_valid = 1; commit_seq = SEQ_W'(s);
    @(negedge clk); commit_valid = 0;
  endtask
  task automatic do_squash(int s);
    squash_valid = 1; squash_seq = SEQ_W'(s);
    @(negedge clk); squash_valid = 0;
  endtask
  task automatic do_read();
    viol_read = 1;
    @(negedge clk); viol_read = 0;
  endtask

  task automatic t_reset();
    chk("R1 count", int'(lq_count), 0);
    chk("R1 full", int'(alloc_full), 0);
    chk("R1 idx", int'(alloc_idx), 0);
    chk("R1 viol", int'(viol_valid), 0);
    chk("R1 fault", int'(st_fault), 0);
    chk("R1 blk", int'(blk_pending), 0);
  endtask

  task automatic t_fill();
    for (int s = 10; s < 18; s++) begin
      chk("R2 index order", int'(alloc_idx), s - 10);
      do_alloc(s);
    end
    chk("R2 count", int'(lq_count), 8);
    chk("R3 full", int'(alloc_full), 1);
    do_alloc(18);
    chk("R3 refused", int'(lq_count), 8);
  endtask

  task automatic t_commit();
    do_commit(12);
    chk("R4 retire three", int'(lq_count), 5);
    chk("R4 not full", int'(alloc_full), 0);
    chk("R4 wrap idx", int'(alloc_idx), 0);
    do_alloc(18);
    chk("R4 reuse slot", int'(slot_of[18]), 0);
    do_commit(9);
    chk("R4 none older", int'(lq_count), 6);
  endtask

  task automatic t_squash();
    do_squash(15);
    chk("R5 squash count", int'(lq_count), 3);
    chk("R5 idx rollback", int'(alloc_idx), 6);
    alloc_valid = 1; alloc_seq = 16; squash_valid = 1; squash_seq = 14;
    @(negedge clk); alloc_valid = 0; squash_valid = 0;
    chk("R5 squash priority count", int'(lq_count), 2);
    chk("R5 squash priority idx", int'(alloc_idx), 5);
    do_commit(100);
    chk("R4 drain", int'(lq_count), 0);
  endtask

  task automatic t_conflict();
    for (int s = 20; s < 25; s++) do_alloc(s);
    do_upd(20, 'h1234);
    do_upd(21, 'h5600);
    do_upd(23, 'h12FF);
    do_upd(24, 'h1200);
    do_store(19, 'h1300);
    chk("R7 other region", int'(st_fault), 0);
    chk("R7 no record", int'(viol_valid), 0);
    do_store(22, 'h5610);
    chk("R8 older load ignored", int'(st_fault), 0);
    do_store(21, 'h0010);
    chk("R8 no address ignored", int'(viol_valid), 0);
    do_store(21, 'h1210);
    chk("R6 fault", int'(st_fault), 1);
    chk("R6 record", int'(viol_valid), 1);
    chk("R9 oldest seq", int'(viol_seq), 23);
    chk("R9 oldest idx", int'(viol_idx), int'(slot_of[23]));
    chk("R6 pulse", int'(st_fault), 1);
    @(negedge clk);
    chk("R6 pulse ends", int'(st_fault), 0);
  endtask

  task automatic t_hold();
    do_store(20, 'h1201);
    chk("R10 no fault while held", int'(st_fault), 0);
    chk("R10 record kept", int'(viol_seq), 23);
    do_read();
    chk("R10 read clears", int'(viol_valid), 0);
    do_store(23, 'h12AA);
    chk("R7 low bits ignored", int'(st_fault), 1);
    chk("R9 next oldest", int'(viol_seq), 24);
    do_read();
  endtask

  task automatic t_blocked();
    blk_set = 1; blk_seq = 30;
    @(negedge clk); blk_set = 0;
    chk("R11 set", int'(blk_pending), 1);
    do_squash(30);
    chk("R11 equal keeps", int'(blk_pending), 1);
    do_squash(29);
    chk("R11 older clears", int'(blk_pending), 0);
    chk("R5 nothing removed", int'(lq_count), 5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_fill();
    t_commit();
    t_squash();
    t_conflict();
    t_hold();
    t_blocked();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule